// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every condition that may restart the chip into a single, clean, synchronous chip reset. The conditions are power-up, a supply brownout, an active-low external reset pin, a watchdog timeout, a software request and a serial break. The external pin and the brownout detector output are asynchronous, so each passes through a two-flop synchronizer. The external pin also goes through a qualification state machine. A short low pulse on the pin is ignored. The pin counts as a reset request only after it has been seen low on several consecutive clocks.

A second state machine drives the chip reset. It has three states. RUN means no reset is present. HOLD means at least one source is present. STRETCH means the sources are gone and a counter is running. The transitions are: RUN to HOLD when a source appears; HOLD to STRETCH when all sources are gone; STRETCH back to HOLD if a source comes back; STRETCH to RUN when the counter expires. The pin qualifier has three states of its own. IDLE means the pin is high. QUAL means the pin is low and being counted. TAKEN means the low level has been accepted. The transitions are: IDLE to QUAL on a low sample; QUAL to TAKEN after enough low samples; any state to IDLE on a high sample. Power-up is a synchronous reset of the whole block and forces HOLD.

The block has a small register bus. Software can read one sticky flag per cause and clear it by writing 0. Software can also request a reset. It can also switch the brownout detector so that it raises an interrupt instead of a reset.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is 1. On the first clock after `por_i` falls, the cause register shows power-on flag (bit 4) = 1 and bits 3..0 = 0. The brownout flag (bit 5) equals the synchronized brownout detector level seen during power-up. The control register reads 0.
- R2: The external pin is accepted as a reset source only after FILT_LEN (4) consecutive low samples at the synchronizer output. A low pulse 3 clocks long produces no reset. A pulse 4 clocks long produces one.
- R3: Any present source asserts `chip_rst_o` on the next clock. The sources are: qualified pin, software request, `wdt_i`, `brk_i`, and synchronized brownout when not in interrupt mode.
- R4: `chip_rst_o` stays high for exactly STRETCH_LEN (16) clocks after the last source disappears. So a source present for N clocks gives a reset N+16 clocks long. A new source during the stretch restarts the count.
- R5: Cause register at address 0 holds bit 0 external, bit 1 software, bit 2 watchdog, bit 3 break, bit 4 power-on, bit 5 brownout; bits 7..6 read 0. A flag stays set until software writes 0 to that bit. Writing 1 leaves it unchanged.
- R6: Writing a 1 to bit 0 of the control register (address 1) issues one software reset request. Bit 0 always reads back 0.
- R7: With control bit 1 set, a brownout drives `bo_irq_o` high, three clocks after the detector input. It causes no reset and does not set the brownout flag.
- R8: Each reset source sets its own cause flag (positions as in R5). If a set and a software clear of the same flag occur together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running block clock |
| por_i | input | 1 | Power-on detector output, active high, synchronous reset of the block |
| bod_i | input | 1 | Brownout detector output, asynchronous, active high |
| ext_rst_n_i | input | 1 | External reset pin, asynchronous, active low |
| wdt_i | input | 1 | Watchdog timeout request, synchronous |
| brk_i | input | 1 | Serial break request, synchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 cause flags, 1 control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register, combinational |
| chip_rst_o | output | 1 | Stretched synchronous chip reset, active high |
| bo_irq_o | output | 1 | Brownout interrupt (interrupt mode only) |

## Verification
The assertions assume three things about the inputs. First, `por_i` is held high for at least three clocks, so the synchronizer stages are flushed before the brownout level is captured. Second, `wdt_i` and `brk_i` come from the block's clock domain. Third, the clock keeps running during power-up. The bench meets these assumptions in the following way. It holds power-up for five clocks. It changes every input half a cycle away from the sampling edge. It drives the watchdog and break requests as whole-cycle pulses. It measures reset length by counting high cycles of `chip_rst_o` over a window longer than any expected pulse. The expected pulse lengths are worked out from the synchronizer depth, the qualification length and the stretch length.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int DATA_W  = 8;
    localparam int CAUSE_W = 6;

    localparam int CB_EXT = 0;
    localparam int CB_SW  = 1;
    localparam int CB_WDT = 2;
    localparam int CB_BRK = 3;
    localparam int CB_POR = 4;
    localparam int CB_BO  = 5;

    localparam logic ADDR_CAUSE = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    localparam int CTL_SWRST = 0;
    localparam int CTL_BOIRQ = 1;

    typedef enum logic [1:0] {
        PF_IDLE,
        PF_QUAL,
        PF_TAKEN
    } pf_state_e;

    typedef enum logic [1:0] {
        RS_RUN,
        RS_HOLD,
        RS_STRETCH
    } rs_state_e;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i) begin
        stage_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter
    import rstc_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic pin_s_i,
    output logic accept_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    pf_state_e      state_q, state_nx;
    logic [CW-1:0]  cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            state_q <= PF_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            PF_IDLE: begin
                if (!pin_s_i) begin
                    state_nx = PF_QUAL;
                    cnt_nx   = CW'(1);
                end
            end
            PF_QUAL: begin
                if (pin_s_i) begin
                    state_nx = PF_IDLE;
                    cnt_nx   = '0;
                end else if (cnt_q == LAST) begin
                    state_nx = PF_TAKEN;
                end else begin
                    cnt_nx = cnt_q + CW'(1);
                end
            end
            PF_TAKEN: begin
                if (pin_s_i) begin
                    state_nx = PF_IDLE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = PF_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (por_i) accept_o <= 1'b0;
        else       accept_o <= (state_nx == PF_TAKEN);
    end

    // R2
    filt_reject_chk: assert property (@(posedge clk_i) disable iff (por_i)
        pin_s_i |=> !accept_o);

    // R2
    filt_low_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(accept_o) |-> !$past(pin_s_i));
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int STRETCH_LEN = 16
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic src_i,
    output logic chip_rst_o
);
    localparam int CW = $clog2(STRETCH_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_LEN - 1);

    rs_state_e      state_q, state_nx;
    logic [CW-1:0]  cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            state_q <= RS_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            RS_RUN: begin
                if (src_i) state_nx = RS_HOLD;
            end
            RS_HOLD: begin
                if (!src_i) begin
                    state_nx = RS_STRETCH;
                    cnt_nx   = '0;
                end
            end
            RS_STRETCH: begin
                if (src_i) begin
                    state_nx = RS_HOLD;
                end else if (cnt_q == LAST) begin
                    state_nx = RS_RUN;
                end else begin
                    cnt_nx = cnt_q + CW'(1);
                end
            end
            default: state_nx = RS_HOLD;
        endcase
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (por_i) chip_rst_o <= 1'b1;
        else       chip_rst_o <= (state_nx != RS_RUN);
    end

    // R3
    src_to_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
        src_i |=> chip_rst_o);
endmodule

// File: rtl/rstc_cause_regs.sv
module rstc_cause_regs
    import rstc_pkg::*;
(
    input  logic               clk_i,
    input  logic               por_i,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic               bo_lvl_i,
    input  logic               bus_wr_i,
    input  logic               bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic [CAUSE_W-1:0] flags_o,
    output logic               sw_req_o,
    output logic               bo_mode_o
);
    localparam int PAD_W = DATA_W - CAUSE_W;

    logic [CAUSE_W-1:0] flags_q;
    logic [CAUSE_W-1:0] clr_mask;
    logic               wr_cause, wr_ctrl;

    assign wr_cause = bus_wr_i && (bus_addr_i == ADDR_CAUSE);
    assign wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign clr_mask = wr_cause ? ~bus_wdata_i[CAUSE_W-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            flags_q         <= '0;
            flags_q[CB_POR] <= 1'b1;
            flags_q[CB_BO]  <= bo_lvl_i;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            bo_mode_o <= 1'b0;
            sw_req_o  <= 1'b0;
        end else begin
            sw_req_o <= wr_ctrl && bus_wdata_i[CTL_SWRST];
            if (wr_ctrl) bo_mode_o <= bus_wdata_i[CTL_BOIRQ];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_CAUSE) begin
            bus_rdata_o = {{PAD_W{1'b0}}, flags_q};
        end else begin
            bus_rdata_o[CTL_BOIRQ] = bo_mode_o;
        end
    end

    assign flags_o = flags_q;

    // R5
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> ((($past(flags_q) & ~$past(clr_mask)) & ~flags_q) == '0));

    // R8
    flag_set_chk: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> (($past(set_i) & ~flags_q) == '0));

    // R1
    por_flags_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(por_i) |-> (flags_q[CB_POR] && (flags_q[CB_BRK:CB_EXT] == '0)));

    // R6
    swreq_src_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(sw_req_o) |-> $past(wr_ctrl && bus_wdata_i[CTL_SWRST]));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int STRETCH_LEN = 16
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              bod_i,
    input  logic              ext_rst_n_i,
    input  logic              wdt_i,
    input  logic              brk_i,
    input  logic              bus_wr_i,
    input  logic              bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              chip_rst_o,
    output logic              bo_irq_o
);
    localparam int QW = $clog2(STRETCH_LEN + 2);
    localparam logic [QW-1:0] QUIET_MAX = QW'(STRETCH_LEN + 1);

    logic [1:0]         async_s;
    logic               pin_s, bod_s;
    logic               ext_acc;
    logic               sw_req, bo_mode;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] cause_flags;
    logic               any_src;

    rstc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk_i (clk_i),
        .d_i   ({bod_i, ext_rst_n_i}),
        .q_o   (async_s)
    );
    assign pin_s = async_s[0];
    assign bod_s = async_s[1];

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .pin_s_i  (pin_s),
        .accept_o (ext_acc)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[CB_EXT] = ext_acc;
        set_vec[CB_SW]  = sw_req;
        set_vec[CB_WDT] = wdt_i;
        set_vec[CB_BRK] = brk_i;
        set_vec[CB_BO]  = bod_s && !bo_mode;
    end
    assign any_src = |set_vec;

    rstc_cause_regs u_regs (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .set_i       (set_vec),
        .bo_lvl_i    (bod_s),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .flags_o     (cause_flags),
        .sw_req_o    (sw_req),
        .bo_mode_o   (bo_mode)
    );

    rstc_seq #(.STRETCH_LEN(STRETCH_LEN)) u_seq (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .src_i      (any_src),
        .chip_rst_o (chip_rst_o)
    );

    always_ff @(posedge clk_i) begin
        if (por_i) bo_irq_o <= 1'b0;
        else       bo_irq_o <= bod_s && bo_mode;
    end

    // checker state: clocks since a source was last present
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk_i) begin
        if (por_i || any_src)      quiet_q <= '0;
        else if (quiet_q != QUIET_MAX) quiet_q <= quiet_q + QW'(1);
    end

    // R1
    por_release_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(por_i) |-> chip_rst_o);

    // R4
    stretch_len_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !chip_rst_o |-> (quiet_q == QUIET_MAX));

    // R7
    boirq_noflag_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(cause_flags[CB_BO]) |-> !$past(bo_mode));
endmodule

// File: tb/rstc_top_test.sv
`timescale 1ns/100ps
module rstc_top_test;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bod = 1'b0;
    logic       ext_n = 1'b1;
    logic       wdt = 1'b0;
    logic       brk = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       chip_rst;
    logic       bo_irq;

    int checks = 0;
    int fails  = 0;
    int hi_cnt = 0;

    always #2 clk = ~clk;

    rstc_top uut (
        .clk_i       (clk),
        .por_i       (por),
        .bod_i       (bod),
        .ext_rst_n_i (ext_n),
        .wdt_i       (wdt),
        .brk_i       (brk),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .chip_rst_o  (chip_rst),
        .bo_irq_o    (bo_irq)
    );

    always @(negedge clk) if (chip_rst === 1'b1) hi_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #0.2;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        tick();
        addr = a;
        #0.2;
        d = rdata;
    endtask

    task automatic wreg(input logic a, input logic [7:0] d);
        tick();
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic t_power_up(input logic bo_lvl, input logic [7:0] exp_cause);
        logic [7:0] d;
        int start;
        tick();
        por = 1'b1; bod = bo_lvl;
        ticks(5);
        chk("R1 reset during power-up", int'(chip_rst), 1);
        rd(1'b0, d);
        chk("R1 cause after power-up", int'(d), int'(exp_cause));
        rd(1'b1, d);
        chk("R1 control cleared", int'(d), 0);
        bod = 1'b0;
        ticks(3);
        start = hi_cnt;
        por = 1'b0;
        ticks(30);
        chk("R4 stretch after power-up", hi_cnt - start, 16);
        wreg(1'b0, 8'h00);
    endtask

    task automatic t_ext(input int len, input int exp_hi, input logic [7:0] exp_cause);
        logic [7:0] d;
        int start;
        wreg(1'b0, 8'h00);
        start = hi_cnt;
        ext_n = 1'b0;
        ticks(len);
        ext_n = 1'b1;
        ticks(45);
        chk("R2 external pin reset length", hi_cnt - start, exp_hi);
        rd(1'b0, d);
        chk("R8 external flag", int'(d), int'(exp_cause));
    endtask

    task automatic t_software();
        logic [7:0] d;
        int start;
        wreg(1'b0, 8'h00);
        start = hi_cnt;
        wreg(1'b1, 8'h01);
        ticks(40);
        chk("R6 software reset length", hi_cnt - start, 17);
        rd(1'b0, d);
        chk("R6 software flag", int'(d), 8'h02);
        rd(1'b1, d);
        chk("R6 control bit0 reads 0", int'(d), 0);
    endtask

    task automatic t_sync_src(input bit use_brk, input int len, input int exp_hi);
        logic [7:0] d;
        int start;
        wreg(1'b0, 8'h00);
        start = hi_cnt;
        if (use_brk) brk = 1'b1; else wdt = 1'b1;
        ticks(len);
        brk = 1'b0; wdt = 1'b0;
        ticks(40);
        chk("R3 R4 source reset length", hi_cnt - start, exp_hi);
        rd(1'b0, d);
        chk("R8 source flag", int'(d), use_brk ? 8'h08 : 8'h04);
    endtask

    task automatic t_retrigger();
        int start;
        start = hi_cnt;
        wdt = 1'b1; tick(); wdt = 1'b0;
        ticks(7);
        wdt = 1'b1; tick(); wdt = 1'b0;
        ticks(40);
        chk("R4 restart during stretch", hi_cnt - start, 25);
    endtask

    task automatic t_flag_write();
        logic [7:0] d;
        wreg(1'b0, 8'h00);
        wdt = 1'b1; tick(); wdt = 1'b0;
        brk = 1'b1; tick(); brk = 1'b0;
        ticks(30);
        rd(1'b0, d);
        chk("R8 two flags set", int'(d), 8'h0C);
        wreg(1'b0, 8'hFF);
        rd(1'b0, d);
        chk("R5 writing ones no effect", int'(d), 8'h0C);
        wreg(1'b0, 8'hFB);
        rd(1'b0, d);
        chk("R5 clear one flag", int'(d), 8'h08);
    endtask

    task automatic t_bo_irq();
        logic [7:0] d;
        int start;
        wreg(1'b0, 8'h00);
        wreg(1'b1, 8'h02);
        rd(1'b1, d);
        chk("R7 control mode readback", int'(d), 8'h02);
        start = hi_cnt;
        bod = 1'b1;
        ticks(6);
        chk("R7 interrupt raised", int'(bo_irq), 1);
        ticks(4);
        bod = 1'b0;
        ticks(6);
        chk("R7 interrupt cleared", int'(bo_irq), 0);
        ticks(20);
        chk("R7 no reset in interrupt mode", hi_cnt - start, 0);
        rd(1'b0, d);
        chk("R7 no brownout flag", int'(d), 0);
        wreg(1'b1, 8'h00);
    endtask

    task automatic t_bo_reset();
        logic [7:0] d;
        int start;
        wreg(1'b0, 8'h00);
        start = hi_cnt;
        bod = 1'b1;
        ticks(5);
        bod = 1'b0;
        ticks(40);
        chk("R3 brownout reset length", hi_cnt - start, 21);
        rd(1'b0, d);
        chk("R8 brownout flag", int'(d), 8'h20);
    endtask

    task automatic run_all();
        logic [7:0] d;
        t_power_up(1'b0, 8'h10);
        chk("R1 idle after stretch", int'(chip_rst), 0);
        t_ext(3, 0, 8'h00);
        t_ext(4, 17, 8'h01);
        t_ext(10, 23, 8'h01);
        t_software();
        t_sync_src(1'b0, 3, 19);
        t_sync_src(1'b1, 1, 17);
        t_retrigger();
        t_flag_write();
        t_bo_irq();
        t_bo_reset();
        // set a watchdog flag, then power up with brownout present
        wdt = 1'b1; tick(); wdt = 1'b0;
        ticks(30);
        t_power_up(1'b1, 8'h30);
        rd(1'b0, d);
        chk("R5 cleared after power-up test", int'(d), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule